// File: doc/BRIEF.md
# TCP/UDP Header Exception Classifier

This block inspects the layer-4 segment of a received IPv4 packet that is not a fragment. It returns one 8-bit exception code for that segment. The segment streams in one byte per cycle, starting at the first byte of the TCP or UDP header and running to the end of the IP payload. A strobe marks the first byte and another marks the last. Side inputs give the IP protocol number, the IP payload length in bytes, the two IPv4 addresses, and a check enable. Upstream logic raises the enable only when the packet is not a fragment and no receive, non-IP or IP-level error has already been flagged.

While the bytes stream in, the block captures the port, length, checksum and TCP flag fields. It also sums the segment in ones-complement arithmetic. On the last byte it adds the pseudo-header (both addresses, the protocol number and the payload length) and checks that the result is all ones. It then evaluates the port, length and flag rules. The lowest failing code is registered, together with an error flag and a TCP-or-UDP indication. That result is presented for one cycle on a valid strobe and is held on the outputs until the next segment completes.

Top module: `l4_exception_classifier`

## Requirements
- R1: The result (`resValid` high for exactly one cycle, with `resErr`, `resCode` and `resTcpUdp`) appears in the clock cycle after the cycle in which the last byte (`byteValid` and `byteLast`) was accepted. The outputs keep their values until the next result.
- R2: `resTcpUdp` is 1 exactly when `ipProto` is 6 (TCP) or 17 (UDP) during the last byte.
- R3: When `checkEnable` is 0, or the protocol is neither 6 nor 17, the result has `resErr` = 0 and `resCode` = 0. In every result, `resErr` is 1 exactly when `resCode` is non-zero.
- R4: The checksum check forms the ones-complement sum of the segment's 16-bit big-endian words, with an odd final byte padded by a zero low byte. It adds the high and low halves of both addresses, the protocol number and `ipPayloadLen`. If the folded sum is not 0xFFFF, the code is 2.
- R5: For UDP, a checksum field (bytes 6 and 7) equal to zero disables the checksum check, and code 2 is never reported.
- R6: For UDP, if the length field (bytes 4 and 5, big-endian) is greater than `ipPayloadLen`, the code is 3. A length equal to `ipPayloadLen` passes.
- R7: If the source port (bytes 0 and 1) or the destination port (bytes 2 and 3) is zero, the code is 4.
- R8: TCP flags are byte 13 (FIN bit 0, SYN bit 1, RST bit 2, URG bit 5). The value 0x01 (only FIN set) gives code 8. The value 0x00 (no flag set) gives code 9.
- R9: For TCP, FIN and RST together give 10, SYN and URG give 11, SYN and RST give 12, and SYN and FIN give 13. The flag codes 8 to 13 are only ever reported for TCP.
- R10: When several conditions hold, the smallest code is reported, in the order 2, 3, 4, 8, 9, 10, 11, 12, 13.
- R11: During and after reset, `resValid`, `resErr`, `resCode` and `resTcpUdp` are all 0.
- R12: A byte is taken only when `byteValid` is high and either `byteStart` is high or a segment is open. Bytes seen after a segment has ended and before the next start produce no result. Header bytes that never arrive read as zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rstN | input | 1 | Asynchronous reset, active low |
| byteValid | input | 1 | A segment byte is present on `byteData` |
| byteStart | input | 1 | This byte is offset 0 of a new segment |
| byteLast | input | 1 | This byte is the final byte of the segment |
| byteData | input | 8 | Segment byte |
| ipProto | input | 8 | IP protocol number, held for the whole segment |
| ipPayloadLen | input | 16 | IP payload length in bytes, held for the whole segment |
| ipSrcAddr | input | 32 | IPv4 source address for the pseudo-header |
| ipDstAddr | input | 32 | IPv4 destination address for the pseudo-header |
| checkEnable | input | 1 | The segment is eligible for layer-4 checks |
| resValid | output | 1 | One-cycle strobe marking a new result |
| resErr | output | 1 | Layer-4 exception detected |
| resCode | output | 8 | Exception code, 0 when there is no exception |
| resTcpUdp | output | 1 | The protocol was TCP or UDP |

## Verification
Each of the four outputs is due exactly one clock after the edge that accepts the last byte. No other output timing exists, because every checksum fold and every rule is resolved within that last-byte cycle. The bench's behavioural model updates its expected outputs when it drives a byte. It compares all four outputs at the following falling edge, so on every cycle it checks both the strobe and the value held since the previous result. The side inputs change only after a full idle cycle that follows the last byte, so the value each result depends on is unambiguous.

// File: rtl/l4cls_pkg.sv
package l4cls_pkg;

  parameter int POS_W = 5;

  localparam logic [7:0] PROTO_TCP = 8'd6;
  localparam logic [7:0] PROTO_UDP = 8'd17;

  localparam int OFF_SRC_HI   = 0;
  localparam int OFF_SRC_LO   = 1;
  localparam int OFF_DST_HI   = 2;
  localparam int OFF_DST_LO   = 3;
  localparam int OFF_ULEN_HI  = 4;
  localparam int OFF_ULEN_LO  = 5;
  localparam int OFF_UCSUM_HI = 6;
  localparam int OFF_UCSUM_LO = 7;
  localparam int OFF_TFLAGS   = 13;

  localparam int PSEUDO_WORDS = 6;

  typedef enum logic [7:0] {
    CODE_NONE    = 8'd0,
    CODE_CSUM    = 8'd2,
    CODE_ULEN    = 8'd3,
    CODE_PORT    = 8'd4,
    CODE_FINONLY = 8'd8,
    CODE_NOFLAG  = 8'd9,
    CODE_FINRST  = 8'd10,
    CODE_SYNURG  = 8'd11,
    CODE_SYNRST  = 8'd12,
    CODE_SYNFIN  = 8'd13
  } l4Code_e;

  typedef struct packed {
    logic             clear;
    logic             take;
    logic             done;
    logic             lowLane;
    logic [POS_W-1:0] pos;
  } l4Strobe_t;

  function automatic l4Code_e tcpFlagCode(input logic [7:0] f);
    l4Code_e c;
    c = CODE_NONE;
    if (f == 8'h01)                 c = CODE_FINONLY;
    else if (f == 8'h00)            c = CODE_NOFLAG;
    else if (f[0] && f[2])          c = CODE_FINRST;
    else if (f[1] && f[5])          c = CODE_SYNURG;
    else if (f[1] && f[2])          c = CODE_SYNRST;
    else if (f[1] && f[0])          c = CODE_SYNFIN;
    return c;
  endfunction

endpackage

// File: rtl/l4cls_ctrl.sv
module l4cls_ctrl
  import l4cls_pkg::*;
(
  input  logic      clk,
  input  logic      rstN,
  input  logic      byteValid,
  input  logic      byteStart,
  input  logic      byteLast,
  output l4Strobe_t strobe
);

  localparam logic [POS_W-1:0] POS_MAX = '1;

  logic             openQ;
  logic             laneQ;
  logic [POS_W-1:0] posQ;
  logic             accept;
  logic             curLow;
  logic [POS_W-1:0] curPos;

  always_comb begin
    accept         = byteValid && (byteStart || openQ);
    curPos         = byteStart ? '0 : posQ;
    curLow         = byteStart ? 1'b0 : laneQ;
    strobe.clear   = byteValid && byteStart;
    strobe.take    = accept;
    strobe.done    = accept && byteLast;
    strobe.lowLane = curLow;
    strobe.pos     = curPos;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      openQ <= 1'b0;
      laneQ <= 1'b0;
      posQ  <= '0;
    end else if (accept) begin
      openQ <= !byteLast;
      laneQ <= !curLow;
      posQ  <= (curPos == POS_MAX) ? POS_MAX : curPos + 1'b1;
    end
  end

  // R12: once a segment has ended, only a start byte can be taken next cycle
  a_r12_restart_needs_start: assert property (@(posedge clk) disable iff (!rstN)
    strobe.done |=> (!strobe.take || strobe.clear));

endmodule

// File: rtl/l4cls_dpath.sv
module l4cls_dpath
  import l4cls_pkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  l4Strobe_t   strobe,
  input  logic [7:0]  byteData,
  input  logic [7:0]  ipProto,
  input  logic [15:0] ipPayloadLen,
  input  logic [31:0] ipSrcAddr,
  input  logic [31:0] ipDstAddr,
  input  logic        checkEnable,
  output logic        resValid,
  output logic        resErr,
  output logic [7:0]  resCode,
  output logic        resTcpUdp
);

  localparam int ACC_W   = 17;
  localparam int PSUM_W  = 16 + $clog2(PSEUDO_WORDS);
  localparam int TOTAL_W = PSUM_W + 1;

  logic [15:0] srcQ, dstQ, ulenQ, ucsQ;
  logic [15:0] srcN, dstN, ulenN, ucsN;
  logic [7:0]  flagQ, flagN;

  logic [ACC_W-1:0] accQ, accBase, accSum, accN, laneWord;
  logic [15:0]      pseudoWord [PSEUDO_WORDS];
  logic [PSUM_W-1:0]  pseudoSum;
  logic [TOTAL_W-1:0] totalSum;
  logic [16:0]      fold1;
  logic [15:0]      fold2;

  logic    isTcp, isUdp, runCheck, csumBad, lenBad, portBad, flagBad, anyBad;
  l4Code_e flagCode, codeN, codeQ;
  logic    errQ, validQ, tcpUdpQ;

  // field capture by byte position
  always_comb begin
    srcN  = strobe.clear ? '0 : srcQ;
    dstN  = strobe.clear ? '0 : dstQ;
    ulenN = strobe.clear ? '0 : ulenQ;
    ucsN  = strobe.clear ? '0 : ucsQ;
    flagN = strobe.clear ? '0 : flagQ;
    if (strobe.take) begin
      case (int'(strobe.pos))
        OFF_SRC_HI:   srcN[15:8]  = byteData;
        OFF_SRC_LO:   srcN[7:0]   = byteData;
        OFF_DST_HI:   dstN[15:8]  = byteData;
        OFF_DST_LO:   dstN[7:0]   = byteData;
        OFF_ULEN_HI:  ulenN[15:8] = byteData;
        OFF_ULEN_LO:  ulenN[7:0]  = byteData;
        OFF_UCSUM_HI: ucsN[15:8]  = byteData;
        OFF_UCSUM_LO: ucsN[7:0]   = byteData;
        OFF_TFLAGS:   flagN       = byteData;
        default: ;
      endcase
    end
  end

  // running ones-complement sum with end-around carry
  always_comb begin
    accBase  = strobe.clear ? '0 : accQ;
    laneWord = strobe.lowLane ? {9'd0, byteData} : {1'b0, byteData, 8'd0};
    accSum   = {1'b0, accBase[15:0]} + {16'd0, accBase[16]} + laneWord;
    accN     = strobe.take ? accSum : accQ;
  end

  // pseudo-header words
  assign pseudoWord[0] = ipSrcAddr[31:16];
  assign pseudoWord[1] = ipSrcAddr[15:0];
  assign pseudoWord[2] = ipDstAddr[31:16];
  assign pseudoWord[3] = ipDstAddr[15:0];
  assign pseudoWord[4] = {8'd0, ipProto};
  assign pseudoWord[5] = ipPayloadLen;

  generate
    genvar gw;
    logic [PSUM_W-1:0] partial [PSEUDO_WORDS+1];
    assign partial[0] = '0;
    for (gw = 0; gw < PSEUDO_WORDS; gw++) begin : g_pseudo
      assign partial[gw+1] = partial[gw] + {{(PSUM_W-16){1'b0}}, pseudoWord[gw]};
    end
    assign pseudoSum = partial[PSEUDO_WORDS];
  endgenerate

  always_comb begin
    totalSum = {{(TOTAL_W-16){1'b0}}, accN[15:0]}
             + {{(TOTAL_W-1){1'b0}}, accN[16]}
             + {1'b0, pseudoSum};
    fold1 = {1'b0, totalSum[15:0]} + {{(17-(TOTAL_W-16)){1'b0}}, totalSum[TOTAL_W-1:16]};
    fold2 = fold1[15:0] + {15'd0, fold1[16]};
  end

  // rule evaluation on the final byte
  always_comb begin
    isTcp    = (ipProto == PROTO_TCP);
    isUdp    = (ipProto == PROTO_UDP);
    runCheck = checkEnable && (isTcp || isUdp);
    csumBad  = (fold2 != 16'hFFFF) && !(isUdp && (ucsN == 16'd0));
    lenBad   = isUdp && (ulenN > ipPayloadLen);
    portBad  = (srcN == 16'd0) || (dstN == 16'd0);
    flagCode = tcpFlagCode(flagN);
    flagBad  = isTcp && (flagCode != CODE_NONE);
    anyBad   = runCheck && (csumBad || lenBad || portBad || flagBad);
    if (!runCheck)    codeN = CODE_NONE;
    else if (csumBad) codeN = CODE_CSUM;
    else if (lenBad)  codeN = CODE_ULEN;
    else if (portBad) codeN = CODE_PORT;
    else if (isTcp)   codeN = flagCode;
    else              codeN = CODE_NONE;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      srcQ    <= '0;
      dstQ    <= '0;
      ulenQ   <= '0;
      ucsQ    <= '0;
      flagQ   <= '0;
      accQ    <= '0;
      validQ  <= 1'b0;
      errQ    <= 1'b0;
      codeQ   <= CODE_NONE;
      tcpUdpQ <= 1'b0;
    end else begin
      srcQ   <= srcN;
      dstQ   <= dstN;
      ulenQ  <= ulenN;
      ucsQ   <= ucsN;
      flagQ  <= flagN;
      accQ   <= accN;
      validQ <= strobe.done;
      if (strobe.done) begin
        errQ    <= anyBad;
        codeQ   <= codeN;
        tcpUdpQ <= isTcp || isUdp;
      end
    end
  end

  assign resValid  = validQ;
  assign resErr    = errQ;
  assign resCode   = codeQ;
  assign resTcpUdp = tcpUdpQ;

  // R3: the error flag and the priority encoder agree
  a_r3_err_matches_code: assert property (@(posedge clk) disable iff (!rstN)
    resErr == (resCode != 8'd0));

  // R1: outputs hold between result strobes
  a_r1_hold_when_idle: assert property (@(posedge clk) disable iff (!rstN)
    !resValid |-> ($stable(resCode) && $stable(resErr) && $stable(resTcpUdp)));

endmodule

// File: rtl/l4_exception_classifier.sv
module l4_exception_classifier
  import l4cls_pkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  logic        byteValid,
  input  logic        byteStart,
  input  logic        byteLast,
  input  logic [7:0]  byteData,
  input  logic [7:0]  ipProto,
  input  logic [15:0] ipPayloadLen,
  input  logic [31:0] ipSrcAddr,
  input  logic [31:0] ipDstAddr,
  input  logic        checkEnable,
  output logic        resValid,
  output logic        resErr,
  output logic [7:0]  resCode,
  output logic        resTcpUdp
);

  l4Strobe_t strobe;

  l4cls_ctrl i_ctrl (
    .clk       (clk),
    .rstN      (rstN),
    .byteValid (byteValid),
    .byteStart (byteStart),
    .byteLast  (byteLast),
    .strobe    (strobe)
  );

  l4cls_dpath i_dpath (
    .clk          (clk),
    .rstN         (rstN),
    .strobe       (strobe),
    .byteData     (byteData),
    .ipProto      (ipProto),
    .ipPayloadLen (ipPayloadLen),
    .ipSrcAddr    (ipSrcAddr),
    .ipDstAddr    (ipDstAddr),
    .checkEnable  (checkEnable),
    .resValid     (resValid),
    .resErr       (resErr),
    .resCode      (resCode),
    .resTcpUdp    (resTcpUdp)
  );

  // R1: a result strobe follows a last byte
  a_r1_valid_follows_last: assert property (@(posedge clk) disable iff (!rstN)
    resValid |-> $past(byteValid && byteLast));

  // R2: protocol indication matches the protocol seen with the last byte
  a_r2_tcpudp_proto: assert property (@(posedge clk) disable iff (!rstN)
    resValid |-> (resTcpUdp == ($past(ipProto) == PROTO_TCP || $past(ipProto) == PROTO_UDP)));

  // R3: no error without the enable
  a_r3_err_needs_enable: assert property (@(posedge clk) disable iff (!rstN)
    (resValid && resErr) |-> $past(checkEnable));

  // R6: the length code is UDP only
  a_r6_len_udp_only: assert property (@(posedge clk) disable iff (!rstN)
    (resValid && resCode == 8'd3) |-> ($past(ipProto) == PROTO_UDP));

  // R9: flag codes are TCP only
  a_r9_flagcodes_tcp_only: assert property (@(posedge clk) disable iff (!rstN)
    (resValid && resCode >= 8'd8) |-> ($past(ipProto) == PROTO_TCP));

endmodule

// File: tb/test_l4_exception_classifier.sv
module test_l4_exception_classifier;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        byteValid = 1'b0, byteStart = 1'b0, byteLast = 1'b0;
  logic [7:0]  byteData = 8'd0;
  logic [7:0]  ipProto = 8'd6;
  logic [15:0] ipPayloadLen = 16'd0;
  logic [31:0] ipSrcAddr = 32'hC0A8_010A;
  logic [31:0] ipDstAddr = 32'h0A00_FE21;
  logic        checkEnable = 1'b1;
  logic        resValid, resErr, resTcpUdp;
  logic [7:0]  resCode;

  always #5 clk = ~clk;

  l4_exception_classifier i_l4_exception_classifier (.*);

  int vectors = 0;
  int miscompares = 0;
  bit finished = 0;
  string curTag = "R11";

  logic       expValid = 0, expErr = 0, expTcpUdp = 0;
  logic [7:0] expCode = 0;
  logic [7:0] pkt [$];
  logic [7:0] rxBuf [$];
  bit         rxOpen = 0;

  function automatic int onesSum(input logic [7:0] q [$]);
    int s = 0;
    for (int i = 0; i < q.size(); i += 2) begin
      logic [7:0] lo = (i + 1 < q.size()) ? q[i+1] : 8'h00;
      s += int'({q[i], lo});
    end
    s += int'(ipSrcAddr[31:16]) + int'(ipSrcAddr[15:0]);
    s += int'(ipDstAddr[31:16]) + int'(ipDstAddr[15:0]);
    s += int'(ipProto) + int'(ipPayloadLen);
    while (s > 'hFFFF) s = (s & 'hFFFF) + (s >>> 16);
    return s;
  endfunction

  function automatic logic [7:0] at(input int i);
    return (i < rxBuf.size()) ? rxBuf[i] : 8'h00;
  endfunction

  function automatic int modelCode();
    bit isT = (ipProto == 8'd6);
    bit isU = (ipProto == 8'd17);
    int f;
    if (!checkEnable || !(isT || isU)) return 0;
    if (onesSum(rxBuf) != 'hFFFF && !(isU && at(6) == 0 && at(7) == 0)) return 2;
    if (isU && int'({at(4), at(5)}) > int'(ipPayloadLen)) return 3;
    if ({at(0), at(1)} == 16'd0 || {at(2), at(3)} == 16'd0) return 4;
    if (isT) begin
      f = int'(at(13));
      if (f == 1) return 8;
      if (f == 0) return 9;
      if ((f & 5) == 5) return 10;
      if ((f & 'h22) == 'h22) return 11;
      if ((f & 6) == 6) return 12;
      if ((f & 3) == 3) return 13;
    end
    return 0;
  endfunction

  task automatic compare();
    vectors++;
    if (resValid !== expValid || resErr !== expErr || resCode !== expCode || resTcpUdp !== expTcpUdp) begin
      miscompares++;
      $display("FAIL %s: valid/err/code/tcpudp actual %0b/%0b/%0d/%0b expected %0b/%0b/%0d/%0b",
               curTag, resValid, resErr, resCode, resTcpUdp, expValid, expErr, expCode, expTcpUdp);
    end
  endtask

  task automatic step(input logic v, input logic s, input logic l, input logic [7:0] d);
    int c;
    @(negedge clk);
    compare();
    byteValid = v; byteStart = s; byteLast = l; byteData = d;
    expValid = 0;
    if (v && (s || rxOpen)) begin
      if (s) rxBuf.delete();
      rxBuf.push_back(d);
      rxOpen = !l;
      if (l) begin
        c = modelCode();
        expValid  = 1;
        expCode   = 8'(c);
        expErr    = (c != 0);
        expTcpUdp = (ipProto == 8'd6 || ipProto == 8'd17);
      end
    end
  endtask

  task automatic sendPkt(input string tag, input int gapAt, input bit idleAfter);
    curTag = tag;
    for (int i = 0; i < pkt.size(); i++) begin
      if (i == gapAt) begin
        step(0, 0, 0, 8'hEE);
        step(0, 0, 0, 8'h5A);
      end
      step(1, i == 0, i == pkt.size() - 1, pkt[i]);
    end
    if (idleAfter) step(0, 0, 0, 8'h00);
  endtask

  task automatic buildTcp(input logic [15:0] sp, input logic [15:0] dp, input logic [7:0] fl, input int pay);
    pkt.delete();
    pkt.push_back(sp[15:8]); pkt.push_back(sp[7:0]);
    pkt.push_back(dp[15:8]); pkt.push_back(dp[7:0]);
    for (int i = 0; i < 8; i++) pkt.push_back(8'(i * 29 + 17));
    pkt.push_back(8'h50); pkt.push_back(fl);
    pkt.push_back(8'h20); pkt.push_back(8'h00);
    pkt.push_back(8'h00); pkt.push_back(8'h00);
    pkt.push_back(8'h00); pkt.push_back(8'h00);
    for (int i = 0; i < pay; i++) pkt.push_back(8'(i * 7 + 3));
    ipProto = 8'd6;
    ipPayloadLen = 16'(pkt.size());
  endtask

  task automatic buildUdp(input logic [15:0] sp, input logic [15:0] dp, input int pay);
    logic [15:0] len = 16'(8 + pay);
    pkt.delete();
    pkt.push_back(sp[15:8]); pkt.push_back(sp[7:0]);
    pkt.push_back(dp[15:8]); pkt.push_back(dp[7:0]);
    pkt.push_back(len[15:8]); pkt.push_back(len[7:0]);
    pkt.push_back(8'h00); pkt.push_back(8'h00);
    for (int i = 0; i < pay; i++) pkt.push_back(8'(i * 13 + 101));
    ipProto = 8'd17;
    ipPayloadLen = len;
  endtask

  task automatic fixCsum(input int off);
    logic [15:0] c;
    pkt[off] = 8'h00; pkt[off+1] = 8'h00;
    c = ~16'(onesSum(pkt));
    pkt[off] = c[15:8]; pkt[off+1] = c[7:0];
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      miscompares++;
      $display("FAIL R1: watchdog expired, actual still running, expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
      $finish;
    end
  end

  initial begin
    // R11: reset state
    repeat (2) @(negedge clk);
    compare();
    rstN = 1'b1;
    step(0, 0, 0, 8'h00);

    // R4/R2: clean TCP, ACK only
    buildTcp(16'd1234, 16'd80, 8'h10, 12); fixCsum(16);
    sendPkt("R4 good tcp", -1, 1);
    // R4: corrupted TCP
    buildTcp(16'd1234, 16'd80, 8'h10, 12); fixCsum(16); pkt[25] = pkt[25] ^ 8'h40;
    sendPkt("R4 bad tcp csum", -1, 1);
    // R4: odd-length UDP, good, with mid-segment gap
    buildUdp(16'd5353, 16'd53, 5); fixCsum(6);
    sendPkt("R4 odd udp good", 4, 1);
    buildUdp(16'd5353, 16'd53, 5); fixCsum(6); pkt[12] = pkt[12] + 8'd1;
    sendPkt("R4 odd udp bad", -1, 1);
    // R5: UDP zero checksum with garbage payload
    buildUdp(16'd4000, 16'd4001, 9);
    sendPkt("R5 udp zero csum", -1, 1);
    // R6: UDP length beyond payload, and equal boundary
    buildUdp(16'd4000, 16'd4001, 6); pkt[5] = pkt[5] + 8'd1; fixCsum(6);
    sendPkt("R6 udp len over", -1, 1);
    buildUdp(16'd4000, 16'd4001, 6); fixCsum(6);
    sendPkt("R6 udp len equal", -1, 1);
    // R7: zero ports
    buildTcp(16'd0, 16'd443, 8'h18, 4); fixCsum(16);
    sendPkt("R7 tcp src zero", -1, 1);
    buildUdp(16'd999, 16'd0, 3); fixCsum(6);
    sendPkt("R7 udp dst zero", -1, 1);
    // R8: FIN only, no flags, FIN+ACK legal
    buildTcp(16'd10, 16'd20, 8'h01, 0); fixCsum(16);
    sendPkt("R8 fin only", -1, 1);
    buildTcp(16'd10, 16'd20, 8'h00, 3); fixCsum(16);
    sendPkt("R8 no flags", -1, 1);
    buildTcp(16'd10, 16'd20, 8'h11, 3); fixCsum(16);
    sendPkt("R8 fin ack ok", -1, 1);
    // R9: illegal pairs
    buildTcp(16'd10, 16'd20, 8'h05, 2); fixCsum(16);
    sendPkt("R9 fin rst", -1, 1);
    buildTcp(16'd10, 16'd20, 8'h22, 2); fixCsum(16);
    sendPkt("R9 syn urg", -1, 1);
    buildTcp(16'd10, 16'd20, 8'h06, 2); fixCsum(16);
    sendPkt("R9 syn rst", -1, 1);
    buildTcp(16'd10, 16'd20, 8'h03, 2); fixCsum(16);
    sendPkt("R9 syn fin", -1, 1);
    // R10: priorities
    buildTcp(16'd10, 16'd20, 8'h07, 2); fixCsum(16);
    sendPkt("R10 three flag pairs", -1, 1);
    buildTcp(16'd0, 16'd20, 8'h00, 2); fixCsum(16); pkt[20] = pkt[20] ^ 8'h01;
    sendPkt("R10 csum over port", -1, 1);
    buildUdp(16'd0, 16'd7, 4); pkt[5] = pkt[5] + 8'd3; fixCsum(6);
    sendPkt("R10 len over port", -1, 1);
    buildTcp(16'd0, 16'd20, 8'h03, 2); fixCsum(16);
    sendPkt("R10 port over flags", -1, 1);
    // R3: enable low, and a non-TCP/UDP protocol
    buildTcp(16'd0, 16'd20, 8'h00, 2);
    checkEnable = 1'b0;
    sendPkt("R3 enable low", -1, 1);
    checkEnable = 1'b1;
    buildTcp(16'd0, 16'd20, 8'h00, 2); ipProto = 8'd1;
    sendPkt("R2 R3 icmp", -1, 1);
    // R12: short TCP header, missing fields read as zero
    buildTcp(16'd55, 16'd66, 8'h10, 0); fixCsum(16);
    pkt = pkt[0:9]; ipPayloadLen = 16'(pkt.size());
    sendPkt("R12 short header", -1, 1);
    // R12: stray bytes without start, including a last strobe
    curTag = "R12 stray bytes";
    step(1, 0, 0, 8'h11);
    step(1, 0, 1, 8'h22);
    step(0, 0, 0, 8'h00);
    // R1: back-to-back segments
    buildUdp(16'd7000, 16'd7001, 3); fixCsum(6);
    sendPkt("R1 back to back a", -1, 0);
    pkt[9] = pkt[9] ^ 8'h80;
    sendPkt("R1 back to back b", -1, 1);
    repeat (3) step(0, 0, 0, 8'h00);

    finished = 1;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end

endmodule